// File: doc/BRIEF.md
# Self-Checking Recursive Moving-Average Filter

The block averages a stream of unsigned samples over a window of N = 2^LOG2N accepted samples. It keeps a running sum that adds each new sample and subtracts the one leaving the window. A lone upset in that running sum would otherwise persist for ever. To catch it, a second and much cheaper filter runs beside it. This checker only accumulates a block of N samples and then starts again from zero, so its total is correct once per block. At the last sample of every block the two totals are compared.

A small controller reacts to a disagreement in two steps. It first assumes the checker is at fault: the checker restarts and the controller waits one more block. If the second comparison also disagrees, the main running sum is cleared. It is then refilled over the next N samples while its output is marked invalid. Any upset therefore lasts no more than about 2N samples, even if the input is never quiet. Two single-cycle inputs flip one bit of either accumulator, so that upsets can be emulated.

Top module: `maf_guarded`

## Requirements
- R1: While reset is high and in the cycle after it, y_valid_o, mismatch_o, chk_clr_o and main_clr_o are 0 and y_o is 0.
- R2: After reset, y_valid_o first goes to 1 with the N-th accepted sample (s_valid_i high). From then on it stays 1 unless the main sum is cleared.
- R3: In a cycle with s_valid_i low, y_o and y_valid_o keep their values.
- R4: With no upset, each accepted sample sets y_o to floor(S / N) one cycle later. S is the unsigned sum of the last N accepted samples, including the current one.
- R5: Checkpoints are the accepted samples whose count since reset, starting at 0, is N-1 modulo N. mismatch_o pulses for one cycle, in the cycle after a checkpoint only, when the two totals differ there. It never pulses at the checkpoint that ends a refill.
- R6: A checkpoint mismatch found in the normal checking state pulses chk_clr_o together with mismatch_o, and main_clr_o stays 0. The checker restarts, and with no further upset the next checkpoint reports no mismatch. A checker upset leaves y_o unaffected.
- R7: A mismatch at the checkpoint right after a checker restart pulses main_clr_o together with mismatch_o. The main sum is cleared, and in that cycle y_o is 0 and y_valid_o is 0.
- R8: After a main clear, y_valid_o stays 0 for the next N-1 accepted samples. It returns to 1 with the N-th one, with y_o equal to the average of those N samples.
- R9: A pulse on upset_main_i inverts bit UPSET_BIT of the main running sum. A pulse on upset_chk_i inverts the same bit of the checker total. With the default UPSET_BIT = LOG2N, this is the least significant bit of y_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid_i | input | 1 | Sample strobe |
| s_data_i | input | DW | Unsigned sample |
| upset_main_i | input | 1 | Emulated upset of the main running sum |
| upset_chk_i | input | 1 | Emulated upset of the checker total |
| y_o | output | DW | Windowed average, sum shifted right by LOG2N |
| y_valid_o | output | 1 | y_o holds a full-window average |
| mismatch_o | output | 1 | One-cycle pulse: totals disagreed at a checkpoint |
| chk_clr_o | output | 1 | One-cycle pulse: checker restarted after a first mismatch |
| main_clr_o | output | 1 | One-cycle pulse: main sum cleared after a confirmed mismatch |

## Verification
The assertions assume that two checkpoints are never back to back, which holds for any N of 2 or more. They also assume that upsets only come through the two upset inputs, so a main clear always follows a checker restart. The stimulus pulses the upset inputs only in cycles with no sample, and at most once in any span of several blocks. Each upset is therefore resolved by the two-step procedure before the next one arrives. Random strobe gaps vary where each upset lands within a block and the state the controller is in.

// File: rtl/maf_pkg.sv
package maf_pkg;
  typedef enum logic [1:0] {
    ST_CHECK   = 2'd0,
    ST_RECHECK = 2'd1,
    ST_RECOVER = 2'd2
  } maf_state_e;
endpackage

// File: rtl/maf_run_sum.sv
module maf_run_sum #(
  parameter int DW        = 8,
  parameter int LOG2N     = 4,
  parameter int UPSET_BIT = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  s_valid,
  input  logic [DW-1:0]         s_data,
  input  logic [LOG2N-1:0]      wr_ptr,
  input  logic                  fill,
  input  logic                  clr,
  input  logic                  upset,
  output logic [DW+LOG2N-1:0]   sum_nx
);
  localparam int N  = 1 << LOG2N;
  localparam int SW = DW + LOG2N;
  localparam logic [SW-1:0] FLIP = SW'(1) << UPSET_BIT;

  logic [DW-1:0] line_q [N];
  logic [SW-1:0] sum_q, sum_d;
  logic [DW-1:0] leaving;

  // delay line: one write per accepted sample, no reset (RAM style)
  always_ff @(posedge clk) begin
    if (s_valid) line_q[wr_ptr] <= s_data;
  end

  // during a refill the stored word is stale and counts as zero
  assign leaving = fill ? '0 : line_q[wr_ptr];
  assign sum_nx  = sum_q + {{LOG2N{1'b0}}, s_data} - {{LOG2N{1'b0}}, leaving};

  always_comb begin
    sum_d = sum_q;
    if (clr)          sum_d = '0;
    else if (s_valid) sum_d = sum_nx;
    if (upset)        sum_d = sum_d ^ FLIP;
  end

  always_ff @(posedge clk) begin
    if (rst) sum_q <= '0;
    else     sum_q <= sum_d;
  end
endmodule

// File: rtl/maf_block_sum.sv
module maf_block_sum #(
  parameter int DW        = 8,
  parameter int LOG2N     = 4,
  parameter int UPSET_BIT = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  s_valid,
  input  logic [DW-1:0]         s_data,
  input  logic                  dump,
  input  logic                  upset,
  output logic [DW+LOG2N-1:0]   blk_nx
);
  localparam int SW = DW + LOG2N;
  localparam logic [SW-1:0] FLIP = SW'(1) << UPSET_BIT;

  logic [SW-1:0] acc_q, acc_d;

  assign blk_nx = acc_q + {{LOG2N{1'b0}}, s_data};

  // integrate-and-dump: restart from zero after the block's last sample
  always_comb begin
    acc_d = acc_q;
    if (s_valid) acc_d = dump ? '0 : blk_nx;
    if (upset)   acc_d = acc_d ^ FLIP;
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_d;
  end
endmodule

// File: rtl/maf_ctrl.sv
module maf_ctrl
  import maf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int LOG2N = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  s_valid,
  input  logic [DW+LOG2N-1:0]   sum_nx,
  input  logic [DW+LOG2N-1:0]   blk_nx,
  output logic [LOG2N-1:0]      phase,
  output logic                  last,
  output logic                  fill,
  output logic                  main_clr,
  output logic                  y_valid_o,
  output logic                  mismatch_o,
  output logic                  chk_clr_o,
  output logic                  main_clr_o
);
  maf_state_e state_q, state_d;
  logic       differ, yv_d;

  assign last     = s_valid && (&phase);
  assign differ   = (sum_nx != blk_nx);
  assign fill     = (state_q == ST_RECOVER);
  assign main_clr = last && (state_q == ST_RECHECK) && differ;

  always_comb begin
    state_d = state_q;
    if (last) begin
      unique case (state_q)
        ST_CHECK:   state_d = differ ? ST_RECHECK : ST_CHECK;
        ST_RECHECK: state_d = differ ? ST_RECOVER : ST_CHECK;
        default:    state_d = ST_CHECK;
      endcase
    end
    yv_d = fill ? last : !main_clr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_RECOVER;
      phase      <= '0;
      y_valid_o  <= 1'b0;
      mismatch_o <= 1'b0;
      chk_clr_o  <= 1'b0;
      main_clr_o <= 1'b0;
    end else begin
      mismatch_o <= last && !fill && differ;
      chk_clr_o  <= last && (state_q == ST_CHECK) && differ;
      main_clr_o <= main_clr;
      if (s_valid) begin
        phase     <= phase + 1'b1;
        y_valid_o <= yv_d;
        state_q   <= state_d;
      end
    end
  end
endmodule

// File: rtl/maf_guarded.sv
module maf_guarded #(
  parameter int DW        = 8,
  parameter int LOG2N     = 4,
  parameter int UPSET_BIT = LOG2N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_valid_i,
  input  logic [DW-1:0] s_data_i,
  input  logic          upset_main_i,
  input  logic          upset_chk_i,
  output logic [DW-1:0] y_o,
  output logic          y_valid_o,
  output logic          mismatch_o,
  output logic          chk_clr_o,
  output logic          main_clr_o
);
  localparam int SW = DW + LOG2N;

  logic [SW-1:0]    sum_nx, blk_nx;
  logic [LOG2N-1:0] phase;
  logic             last, fill, main_clr;

  maf_run_sum #(.DW(DW), .LOG2N(LOG2N), .UPSET_BIT(UPSET_BIT)) u_main (
    .clk(clk), .rst(rst), .s_valid(s_valid_i), .s_data(s_data_i),
    .wr_ptr(phase), .fill(fill), .clr(main_clr), .upset(upset_main_i),
    .sum_nx(sum_nx)
  );

  maf_block_sum #(.DW(DW), .LOG2N(LOG2N), .UPSET_BIT(UPSET_BIT)) u_chk (
    .clk(clk), .rst(rst), .s_valid(s_valid_i), .s_data(s_data_i),
    .dump(last), .upset(upset_chk_i), .blk_nx(blk_nx)
  );

  maf_ctrl #(.DW(DW), .LOG2N(LOG2N)) u_ctrl (
    .clk(clk), .rst(rst), .s_valid(s_valid_i), .sum_nx(sum_nx), .blk_nx(blk_nx),
    .phase(phase), .last(last), .fill(fill), .main_clr(main_clr),
    .y_valid_o(y_valid_o), .mismatch_o(mismatch_o), .chk_clr_o(chk_clr_o),
    .main_clr_o(main_clr_o)
  );

  always_ff @(posedge clk) begin
    if (rst)            y_o <= '0;
    else if (s_valid_i) y_o <= main_clr ? '0 : sum_nx[SW-1:LOG2N];
  end
endmodule

// File: rtl/maf_guarded_sva.sv
module maf_guarded_sva #(
  parameter int DW    = 8,
  parameter int LOG2N = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          s_valid_i,
  input logic [DW-1:0] y_o,
  input logic          y_valid_o,
  input logic          mismatch_o,
  input logic          chk_clr_o,
  input logic          main_clr_o
);
  logic [LOG2N-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst)            seen <= '0;
    else if (s_valid_i) seen <= seen + 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!y_valid_o && !mismatch_o && !chk_clr_o && !main_clr_o && y_o == '0));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !s_valid_i |=> ($stable(y_o) && $stable(y_valid_o)));

  p_flag_at_ckpt_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(mismatch_o) |-> ($past(s_valid_i) && (&$past(seen))));

  p_clr_needs_miss_r6: assert property (@(posedge clk) disable iff (rst)
    (chk_clr_o || main_clr_o) |-> mismatch_o);

  p_one_clear_r7: assert property (@(posedge clk) disable iff (rst)
    !(chk_clr_o && main_clr_o));

  p_clear_drops_valid_r8: assert property (@(posedge clk) disable iff (rst)
    main_clr_o |-> (!y_valid_o && y_o == '0));
endmodule

bind maf_guarded maf_guarded_sva #(.DW(DW), .LOG2N(LOG2N)) u_sva (
  .clk(clk), .rst(rst), .s_valid_i(s_valid_i), .y_o(y_o), .y_valid_o(y_valid_o),
  .mismatch_o(mismatch_o), .chk_clr_o(chk_clr_o), .main_clr_o(main_clr_o)
);

// File: tb/maf_guarded_test.sv
module maf_guarded_test;
  localparam int DW    = 8;
  localparam int LOG2N = 4;
  localparam int N     = 1 << LOG2N;
  localparam int SW    = DW + LOG2N;
  localparam logic [SW-1:0] FLIP = SW'(1) << LOG2N;

  logic clk = 1'b0, rst = 1'b1;
  logic s_valid_i = 1'b0, upset_main_i = 1'b0, upset_chk_i = 1'b0;
  logic [DW-1:0] s_data_i = '0;
  logic [DW-1:0] y_o;
  logic y_valid_o, mismatch_o, chk_clr_o, main_clr_o;

  always #10 clk = ~clk;

  maf_guarded #(.DW(DW), .LOG2N(LOG2N)) uut (
    .clk(clk), .rst(rst), .s_valid_i(s_valid_i), .s_data_i(s_data_i),
    .upset_main_i(upset_main_i), .upset_chk_i(upset_chk_i),
    .y_o(y_o), .y_valid_o(y_valid_o), .mismatch_o(mismatch_o),
    .chk_clr_o(chk_clr_o), .main_clr_o(main_clr_o)
  );

  int n_chk = 0, n_fail = 0;
  int c_mis = 0, c_cc = 0, c_mc = 0;
  bit finished = 1'b0;

  // requirement-level reference
  logic [DW-1:0] r_win [N];
  logic [SW-1:0] r_sum, r_blk;
  int            r_cnt, r_st;   // 0 checking, 1 rechecking, 2 refilling
  logic [DW-1:0] e_y;
  bit            e_yv, e_mis, e_cc, e_mc;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic ref_reset();
    r_sum = '0; r_blk = '0; r_cnt = 0; r_st = 2;
    e_y = '0; e_yv = 0; e_mis = 0; e_cc = 0; e_mc = 0;
    for (int i = 0; i < N; i++) r_win[i] = '0;
  endtask

  task automatic ref_step(input bit v, input logic [DW-1:0] d, input bit um, input bit uc);
    logic [SW-1:0] snx, bnx, old;
    bit lst, miss, mclr;
    e_mis = 0; e_cc = 0; e_mc = 0;
    if (v) begin
      old  = (r_st == 2) ? '0 : SW'(r_win[r_cnt]);
      snx  = r_sum + SW'(d) - old;
      bnx  = r_blk + SW'(d);
      lst  = (r_cnt == N - 1);
      miss = (snx != bnx);
      mclr = lst && r_st == 1 && miss;
      e_y  = mclr ? '0 : DW'(snx >> LOG2N);
      e_yv = (r_st == 2) ? lst : !mclr;
      e_mis = lst && r_st != 2 && miss;
      e_cc  = lst && r_st == 0 && miss;
      e_mc  = mclr;
      r_win[r_cnt] = d;
      r_sum = mclr ? '0 : snx;
      r_blk = lst ? '0 : bnx;
      if (lst) begin
        if (r_st == 0)      r_st = miss ? 1 : 0;
        else if (r_st == 1) r_st = miss ? 2 : 0;
        else                r_st = 0;
      end
      r_cnt = (r_cnt + 1) % N;
    end
    if (um) r_sum = r_sum ^ FLIP;
    if (uc) r_blk = r_blk ^ FLIP;
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic step(input bit v, input logic [DW-1:0] d, input bit um, input bit uc);
    logic [DW-1:0] y_before;
    bit yv_before;
    y_before = y_o; yv_before = y_valid_o;
    s_valid_i = v; s_data_i = d; upset_main_i = um; upset_chk_i = uc;
    ref_step(v, d, um, uc);
    @(negedge clk);
    s_valid_i = 1'b0; upset_main_i = 1'b0; upset_chk_i = 1'b0;
    if (!v) begin
      check(y_o == y_before, "R3 y_o held on idle", int'(y_o), int'(y_before));
      check(y_valid_o == yv_before, "R3 y_valid_o held on idle", int'(y_valid_o), int'(yv_before));
    end
    if (e_yv) check(y_o == e_y, "R4 average value", int'(y_o), int'(e_y));
    check(y_valid_o == e_yv, "R2 y_valid_o", int'(y_valid_o), int'(e_yv));
    check(mismatch_o == e_mis, "R5 mismatch_o", int'(mismatch_o), int'(e_mis));
    check(chk_clr_o == e_cc, "R6 chk_clr_o", int'(chk_clr_o), int'(e_cc));
    check(main_clr_o == e_mc, "R7 main_clr_o", int'(main_clr_o), int'(e_mc));
    c_mis += int'(mismatch_o); c_cc += int'(chk_clr_o); c_mc += int'(main_clr_o);
  endtask

  task automatic run_samples(input int count, input int idle_pct);
    int done_n = 0;
    while (done_n < count) begin
      if (($urandom % 100) < idle_pct) step(1'b0, '0, 1'b0, 1'b0);
      else begin
        step(1'b1, DW'($urandom), 1'b0, 1'b0);
        done_n++;
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    if (!finished) begin
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    ref_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(y_valid_o == 0 && mismatch_o == 0 && chk_clr_o == 0 && main_clr_o == 0,
          "R1 flags low in reset", int'(y_valid_o), 0);
    check(y_o == 0, "R1 y_o zero in reset", int'(y_o), 0);
    rst = 1'b0;

    // R2 directed: constant 10 with gaps, valid rises on the N-th sample
    for (int i = 0; i < N; i++) begin
      step(1'b1, 8'd10, 1'b0, 1'b0);
      if (i < N - 1) check(y_valid_o == 0, "R2 not valid before N-th sample", int'(y_valid_o), 0);
      else begin
        check(y_valid_o == 1, "R2 valid at N-th sample", int'(y_valid_o), 1);
        check(y_o == 8'd10, "R4 constant average", int'(y_o), 10);
      end
      step(1'b0, 8'hFF, 1'b0, 1'b0);
    end
    // R4 extremes: full-scale then zero
    for (int i = 0; i < N; i++) step(1'b1, 8'hFF, 1'b0, 1'b0);
    check(y_o == 8'hFF, "R4 full-scale average", int'(y_o), 255);
    for (int i = 0; i < N; i++) step(1'b1, 8'h00, 1'b0, 1'b0);
    check(y_o == 8'h00, "R4 zero average", int'(y_o), 0);

    // random stream, no upsets
    run_samples(300, 30);
    check(c_mis == 0, "R5 no mismatch without upset", c_mis, 0);

    // R6 checker upset in an idle cycle
    c_mis = 0; c_cc = 0; c_mc = 0;
    run_samples(5, 20);
    step(1'b0, '0, 1'b0, 1'b1);
    run_samples(2 * N, 25);
    check(c_mis == 1 && c_cc == 1, "R6 one mismatch and checker restart", c_mis * 10 + c_cc, 11);
    check(c_mc == 0, "R6 main sum untouched", c_mc, 0);

    // R7 / R8 / R9 main upset
    c_mis = 0; c_cc = 0; c_mc = 0;
    run_samples(3, 20);
    step(1'b0, '0, 1'b1, 1'b0);
    step(1'b1, 8'd0, 1'b0, 1'b0);
    check(y_o == e_y, "R9 main upset flips y_o bit 0", int'(y_o), int'(e_y));
    run_samples(3 * N - 1, 25);
    check(c_mis == 2, "R7 two mismatches", c_mis, 2);
    check(c_cc == 1 && c_mc == 1, "R7 restart then main clear", c_cc * 10 + c_mc, 11);
    check(y_valid_o == 1, "R8 valid again after refill", int'(y_valid_o), 1);

    // random stream with sparse upsets
    for (int k = 0; k < 6; k++) begin
      step(1'b0, '0, k[0], !k[0]);
      run_samples(4 * N, 25);
    end
    check(y_valid_o == 1, "R8 recovered at end", int'(y_valid_o), 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule